// File: doc/BRIEF.md
# Virtual Interrupt List Register Bank

This block holds a small set of list entries for a virtualised interrupt CPU interface. Each entry carries a virtual interrupt ID, a two-bit state, a hardware-link flag and a physical interrupt ID. A hypervisor-side write port loads any entry directly. A guest-side port offers two operations. An acknowledge claims the highest-priority pending entry, which is the one with the lowest index. A deactivate, the guest's end-of-interrupt write, retires an active entry by its virtual ID.

When a linked entry is deactivated, the bank sends a one-cycle request to the physical interrupt distributor that carries the entry's physical ID. That request is what lets the distributor drop the physical active state it holds for the guest. The bank also shows a bitmap of empty entries and a packed 4-bit status nibble for each entry.

The acknowledge response and the physical deactivate request are one-cycle pulses with no ready input. The bank never stalls them, so a consumer must take each pulse in the cycle it appears. The write, acknowledge and deactivate inputs are accepted in every cycle without back-pressure.

Top module: `lr_bank`

## Requirements
- R1: After reset every entry is inactive, `empty_map` is all ones, `lr_status` is zero, and `ack_valid`, `hw_err` and `pdeact_valid` are low.
- R2: An accepted host write replaces the entry at `hw_idx` at the next clock edge. Its nibble in `lr_status` (bits 4i+3..4i) then holds the link flag at bit 3, zero at bit 2 and the state at bits 1:0. The state codes are 0 inactive, 1 pending, 2 active and 3 pending+active, so a linked pending entry reads 9 and a linked active entry reads 10.
- R3: A host write that requests state 3 with the link flag set is rejected. The entry keeps its old contents, `hw_err` is high for exactly the following cycle, and no entry ever holds link=1 with state 3.
- R4: Bit i of `empty_map` is 1 exactly when entry i is inactive, whatever its link flag. A linked inactive entry reads nibble 8 and counts as empty.
- R5: An acknowledge selects the lowest-index entry in state 1. One cycle later `ack_valid` pulses with that entry's virtual ID on `ack_vid`, and the entry moves to state 2.
- R6: An acknowledge with no eligible pending entry returns `ack_vid` = 1023 (all ones) with `ack_valid` high, and changes no entry.
- R7: A deactivate whose `eoi_vid` matches an entry in state 2 or 3 moves the lowest-index such entry to state 0 (from 2) or state 1 (from 3).
- R8: A deactivate that retires a linked entry pulses `pdeact_valid` for one cycle, one cycle later, with the entry's physical ID on `pdeact_pid`. Retiring an unlinked entry produces no pulse.
- R9: A deactivate whose ID matches no entry in state 2 or 3 changes no entry and produces no pulse.
- R10: A host write request to an entry takes precedence over a guest acknowledge or deactivate of that entry in the same cycle. The guest operation treats that entry as ineligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Host write request |
| hw_idx | input | IDX_W | Entry index to write |
| hw_vid | input | ID_W | Virtual ID to load |
| hw_state | input | 2 | State to load (0 inactive, 1 pending, 2 active, 3 pending+active) |
| hw_link | input | 1 | Hardware-link flag to load |
| hw_pid | input | ID_W | Physical ID to load |
| hw_err | output | 1 | Pulse: previous host write rejected |
| ack_req | input | 1 | Guest acknowledge request |
| ack_valid | output | 1 | Pulse: acknowledge response |
| ack_vid | output | ID_W | Acknowledged virtual ID, or all ones if none |
| eoi_req | input | 1 | Guest deactivate request |
| eoi_vid | input | ID_W | Virtual ID being deactivated |
| pdeact_valid | output | 1 | Pulse: physical deactivate request |
| pdeact_pid | output | ID_W | Physical ID to deactivate |
| empty_map | output | N_LR | One bit per inactive entry |
| lr_status | output | 4*N_LR | Per-entry nibble {link, 0, state} |

## Verification
The bench builds the bank with its default four entries and 10-bit IDs. With four entries, the full lowest-index ordering can be exercised, with two pending entries separated by idle ones. A bank with no pending entry is also easy to reach, so the spurious all-ones ID can be checked. Ten-bit IDs make the spurious value 1023 exactly. Physical IDs that differ from the virtual ones show that the request carries the linked number and not the guest's.

// File: rtl/lr_pkg.sv
package lr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2,
    ST_PACT = 2'd3
  } lr_state_e;
endpackage

// File: rtl/lr_pick.sv
// Lowest-index first-one finder.
module lr_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lr_entry.sv
// One list entry: host load has priority over guest state moves.
module lr_entry import lr_pkg::*; #(
  parameter int ID_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [ID_W-1:0] wr_vid,
  input  logic [1:0]      wr_state,
  input  logic            wr_link,
  input  logic [ID_W-1:0] wr_pid,
  input  logic            ack_take,
  input  logic            eoi_take,
  output logic [ID_W-1:0] vid,
  output lr_state_e       state,
  output logic            link,
  output logic [ID_W-1:0] pid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid   <= '0;
      state <= ST_IDLE;
      link  <= 1'b0;
      pid   <= '0;
    end else if (wr_en) begin
      vid   <= wr_vid;
      state <= lr_state_e'(wr_state);
      link  <= wr_link;
      pid   <= wr_pid;
    end else if (ack_take) begin
      state <= ST_ACT;
    end else if (eoi_take) begin
      state <= (state == ST_PACT) ? ST_PEND : ST_IDLE;
    end
  end
endmodule

// File: rtl/lr_bank.sv
module lr_bank import lr_pkg::*; #(
  parameter int N_LR = 4,
  parameter int ID_W = 10,
  localparam int IDX_W = (N_LR > 1) ? $clog2(N_LR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en,
  input  logic [IDX_W-1:0]  hw_idx,
  input  logic [ID_W-1:0]   hw_vid,
  input  logic [1:0]        hw_state,
  input  logic              hw_link,
  input  logic [ID_W-1:0]   hw_pid,
  output logic              hw_err,
  input  logic              ack_req,
  output logic              ack_valid,
  output logic [ID_W-1:0]   ack_vid,
  input  logic              eoi_req,
  input  logic [ID_W-1:0]   eoi_vid,
  output logic              pdeact_valid,
  output logic [ID_W-1:0]   pdeact_pid,
  output logic [N_LR-1:0]   empty_map,
  output logic [4*N_LR-1:0] lr_status
);
  localparam logic [ID_W-1:0] SPURIOUS = '1;

  logic [ID_W-1:0] e_vid [N_LR];
  logic [ID_W-1:0] e_pid [N_LR];
  lr_state_e       e_st  [N_LR];
  logic [N_LR-1:0] e_link;

  logic [N_LR-1:0] blk, wr_ok, pend_v, eoi_v, ack_take, eoi_take;
  logic            bad_wr;
  logic            ack_hit, eoi_hit;
  logic [IDX_W-1:0] ack_idx, eoi_idx;

  // Linked entries may not be both pending and active.
  assign bad_wr = hw_link && (hw_state == 2'd3);

  for (genvar g = 0; g < N_LR; g++) begin : g_lr
    assign blk[g]   = hw_en && (hw_idx == IDX_W'(g));
    assign wr_ok[g] = blk[g] && !bad_wr;
    assign pend_v[g] = (e_st[g] == ST_PEND) && !blk[g];
    assign eoi_v[g]  = eoi_req && !blk[g] && (e_vid[g] == eoi_vid) &&
                       ((e_st[g] == ST_ACT) || (e_st[g] == ST_PACT));
    assign ack_take[g] = ack_req && ack_hit && (ack_idx == IDX_W'(g));
    assign eoi_take[g] = eoi_hit && (eoi_idx == IDX_W'(g));

    lr_entry #(.ID_W(ID_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ok[g]),
      .wr_vid   (hw_vid),
      .wr_state (hw_state),
      .wr_link  (hw_link),
      .wr_pid   (hw_pid),
      .ack_take (ack_take[g]),
      .eoi_take (eoi_take[g]),
      .vid      (e_vid[g]),
      .state    (e_st[g]),
      .link     (e_link[g]),
      .pid      (e_pid[g])
    );

    assign empty_map[g]        = (e_st[g] == ST_IDLE);
    assign lr_status[4*g +: 4] = {e_link[g], 1'b0, e_st[g]};
  end

  lr_pick #(.N(N_LR)) u_ack_pick (.req(pend_v), .hit(ack_hit), .idx(ack_idx));
  lr_pick #(.N(N_LR)) u_eoi_pick (.req(eoi_v),  .hit(eoi_hit), .idx(eoi_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_err       <= 1'b0;
      ack_valid    <= 1'b0;
      ack_vid      <= '0;
      pdeact_valid <= 1'b0;
      pdeact_pid   <= '0;
    end else begin
      hw_err    <= hw_en && bad_wr;
      ack_valid <= ack_req;
      if (ack_req) ack_vid <= ack_hit ? e_vid[ack_idx] : SPURIOUS;
      pdeact_valid <= eoi_hit && e_link[eoi_idx];
      if (eoi_hit) pdeact_pid <= e_pid[eoi_idx];
    end
  end
endmodule

// File: rtl/lr_bank_chk.sv
module lr_bank_chk #(
  parameter int N_LR = 4,
  parameter int ID_W = 10,
  localparam int IDX_W = (N_LR > 1) ? $clog2(N_LR) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_en,
  input logic [IDX_W-1:0]  hw_idx,
  input logic [1:0]        hw_state,
  input logic              hw_link,
  input logic              hw_err,
  input logic              ack_req,
  input logic              ack_valid,
  input logic              eoi_req,
  input logic              pdeact_valid,
  input logic [4*N_LR-1:0] lr_status
);
  assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_err |-> $past(hw_en && hw_link && hw_state == 2'd3));

  assert_ack_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_valid);

  assert_ack_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(ack_req));

  assert_pdeact_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pdeact_valid |-> $past(eoi_req));

  for (genvar g = 0; g < N_LR; g++) begin : g_chk
    assert_no_linked_pa_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lr_status[4*g+3] |-> (lr_status[4*g +: 2] != 2'd3));

    assert_host_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_en && hw_idx == IDX_W'(g) && !(hw_link && hw_state == 2'd3)) |=>
        (lr_status[4*g +: 4] == {$past(hw_link), 1'b0, $past(hw_state)}));
  end
endmodule

bind lr_bank lr_bank_chk #(.N_LR(N_LR), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_idx(hw_idx),
  .hw_state(hw_state), .hw_link(hw_link), .hw_err(hw_err),
  .ack_req(ack_req), .ack_valid(ack_valid), .eoi_req(eoi_req),
  .pdeact_valid(pdeact_valid), .lr_status(lr_status)
);

// File: tb/lr_bank_tb.sv
`timescale 1ns/1ps
module lr_bank_tb;
  localparam int N_LR = 4;
  localparam int ID_W = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic hw_en;
  logic [1:0] hw_idx;
  logic [ID_W-1:0] hw_vid, hw_pid, eoi_vid;
  logic [1:0] hw_state;
  logic hw_link, hw_err, ack_req, ack_valid, eoi_req, pdeact_valid;
  logic [ID_W-1:0] ack_vid, pdeact_pid;
  logic [N_LR-1:0] empty_map;
  logic [4*N_LR-1:0] lr_status;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lr_bank #(.N_LR(N_LR), .ID_W(ID_W)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nib(int i);
    return int'(lr_status[4*i +: 4]);
  endfunction

  task automatic wr(int idx, int vid, int st, bit lk, int pid);
    hw_en = 1'b1; hw_idx = 2'(idx); hw_vid = ID_W'(vid);
    hw_state = 2'(st); hw_link = lk; hw_pid = ID_W'(pid);
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic ack();
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
  endtask

  task automatic eoi(int vid);
    eoi_req = 1'b1; eoi_vid = ID_W'(vid);
    @(negedge clk);
    eoi_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 empty", int'(empty_map), 15);
    chk("R1 status", int'(lr_status), 0);
    chk("R1 outs", int'({ack_valid, hw_err, pdeact_valid}), 0);
  endtask

  task automatic t_write();
    wr(0, 5, 1, 1'b1, 33);
    chk("R2 linked pending nibble", nib(0), 9);
    chk("R4 empty bit0", int'(empty_map[0]), 0);
    wr(1, 6, 2, 1'b1, 34);
    chk("R2 linked active nibble", nib(1), 10);
    wr(2, 9, 0, 1'b1, 40);
    chk("R4 linked inactive nibble", nib(2), 8);
    chk("R4 linked inactive empty", int'(empty_map), 4'b1100);
  endtask

  task automatic t_reject();
    wr(2, 11, 3, 1'b1, 41);
    chk("R3 err pulse", int'(hw_err), 1);
    chk("R3 entry kept", nib(2), 8);
    @(negedge clk);
    chk("R3 err one cycle", int'(hw_err), 0);
  endtask

  task automatic t_eoi_link();
    eoi(6);
    chk("R8 pdeact pulse", int'(pdeact_valid), 1);
    chk("R8 pdeact pid", int'(pdeact_pid), 34);
    chk("R7 active to inactive", nib(1), 8);
    chk("R4 empty after eoi", int'(empty_map[1]), 1);
    @(negedge clk);
    chk("R8 pulse one cycle", int'(pdeact_valid), 0);
  endtask

  task automatic t_ack();
    wr(3, 7, 1, 1'b0, 0);
    ack();
    chk("R5 ack valid", int'(ack_valid), 1);
    chk("R5 lowest index first", int'(ack_vid), 5);
    chk("R5 entry0 active", nib(0), 10);
    ack();
    chk("R5 next pending", int'(ack_vid), 7);
    chk("R5 entry3 active", nib(3), 2);
    ack();
    chk("R6 spurious id", int'(ack_vid), 1023);
    chk("R6 no change", int'(lr_status), 16'h2_8_8_A);
  endtask

  task automatic t_eoi_misc();
    eoi(99);
    chk("R9 no pulse", int'(pdeact_valid), 0);
    chk("R9 no change", int'(lr_status), 16'h2_8_8_A);
    eoi(7);
    chk("R8 unlinked no pulse", int'(pdeact_valid), 0);
    chk("R7 unlinked retired", nib(3), 0);
    wr(2, 12, 3, 1'b0, 0);
    chk("R2 pending+active nibble", nib(2), 3);
    eoi(12);
    chk("R7 pa to pending", nib(2), 1);
  endtask

  task automatic t_collision();
    hw_en = 1'b1; hw_idx = 2'd2; hw_vid = 10'd20;
    hw_state = 2'd2; hw_link = 1'b0; hw_pid = 10'd0;
    ack_req = 1'b1;
    @(negedge clk);
    hw_en = 1'b0; ack_req = 1'b0;
    chk("R10 host write wins", nib(2), 2);
    chk("R10 ack sees no pending", int'(ack_vid), 1023);
  endtask

  initial begin
    rst_n = 1'b0; hw_en = 1'b0; hw_idx = '0; hw_vid = '0; hw_state = '0;
    hw_link = 1'b0; hw_pid = '0; ack_req = 1'b0; eoi_req = 1'b0; eoi_vid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_reject();
    t_eoi_link();
    t_ack();
    t_eoi_misc();
    t_collision();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule